// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Tagged Receive Queue and Sticky Error Status

This block recovers characters from an asynchronous serial line and stores every completed character in a receive queue. Each bit is sampled at its centre using a 16x oversampling strobe that is supplied from outside. A character is stored even when it is damaged, and reception goes straight on to the next one. Each queue entry carries its own framing-error and parity-error tag, so software can tell exactly which word was bad.

A single sticky error status bit collects framing and parity errors. Software clears it with a handshake: it must first read the bit as 1 and then write 0. A write of 0 without that read leaves the bit set. Reset and the standby input also clear the bit. Switching the receiver off leaves it unchanged.

Mode inputs select optional parity (odd or even) and one or two stop bits. Baud generation, transmit and interrupt logic sit outside this block.

Top module: `rxline_capture`

## Requirements
- R1: With parity off, a frame made of a low start bit, 8 data bits (least significant first) and a high stop bit is stored in the queue with both tags 0. Each bit is sampled 8 strobes after its leading edge, i.e. at its centre, with 16 strobes per bit.
- R2: A low level on the line that is high again at the centre of the start bit (8 strobes after detection) is discarded, and nothing is stored.
- R3: A stop bit sampled as 0 sets the framing tag (`qFrameErr`=1) of that entry and sets `errFlag`. The damaged character is still stored, and the next frame is received normally.
- R4: With `parityOn`=1 a parity bit follows the last data bit. `parityOdd`=0 expects an even total count of ones across the data and parity bits; `parityOdd`=1 expects an odd count. A mismatch sets the parity tag (`qParityErr`=1) and sets `errFlag`.
- R5: With `twoStop`=1 only the first stop bit is checked. A low second stop bit causes no error and no extra entry.
- R6: `errFlag` clears only on a write of `regWdata`=0 that follows a read (`regRead`) which saw `errFlag`=1, with no other write in between. A write of 0 with no such read, or a write of 1, leaves the flag set.
- R7: When an error is detected in the same cycle as a clearing write, the flag stays 1.
- R8: While `rxEnable`=0 no character is received, and `errFlag` keeps its value.
- R9: `standby`=1 clears `errFlag` and `overrun`. Reset gives an empty queue and both flags at 0.
- R10: When a character completes while the queue is full, the character is dropped, `overrun` becomes 1, and the stored entries are kept.
- R11: The queue returns entries in arrival order. The head is shown at `qData`/`qFrameErr`/`qParityErr`, and `qPop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sampleTick | input | 1 | Oversampling strobe, 16 per bit |
| rxLine | input | 1 | Serial line, idle high |
| rxEnable | input | 1 | Receiver enable |
| parityOn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| twoStop | input | 1 | Two stop bits per frame |
| standby | input | 1 | Low-power entry, clears the status flags |
| regRead | input | 1 | Status read strobe |
| regWrite | input | 1 | Status write strobe |
| regWdata | input | 1 | Value written to the error bit |
| qPop | input | 1 | Remove the head entry |
| errFlag | output | 1 | Sticky receive-error status |
| qData | output | 8 | Head entry data |
| qFrameErr | output | 1 | Head entry framing tag |
| qParityErr | output | 1 | Head entry parity tag |
| qEmpty | output | 1 | Queue empty |
| qFull | output | 1 | Queue full |
| overrun | output | 1 | Character dropped on a full queue |

## Verification
The bench builds the block with a queue depth of 4. A full queue and the overrun drop are then reached after five frames instead of seventeen. The strobe is held high on every clock, so a bit lasts exactly 16 clocks. That makes the edge at which an error sets the flag predictable, so a clearing write can be placed on that exact cycle to show that the set wins.

// File: rtl/rxline_pkg.sv
package rxline_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2
  } rxState_t;

  // strobes from control to datapath, one per sampled bit class
  typedef struct packed {
    logic dataBit;
    logic parBit;
    logic stopBit;
  } rxStrobe_t;
endpackage

// File: rtl/rxline_ctrl.sv
module rxline_ctrl
  import rxline_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DBITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      rxLine,
  input  logic      rxEnable,
  input  logic      parityOn,
  input  logic      twoStop,
  output rxStrobe_t strobe
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DBITS);

  rxState_t       state;
  logic [CW-1:0]  tickCnt;
  logic [BW-1:0]  bitCnt;
  logic           midBit, midStart;

  assign midBit   = (tickCnt == CW'(OSR - 1));
  assign midStart = (tickCnt == CW'(OSR / 2 - 1));

  always_comb begin
    strobe = '0;
    if (sampleTick && midBit) begin
      case (state)
        S_DATA:  strobe.dataBit = 1'b1;
        S_PAR:   strobe.parBit  = 1'b1;
        S_STOP:  strobe.stopBit = 1'b1;
        default: strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!rxEnable) begin
      state   <= S_IDLE;
      tickCnt <= '0;
    end else if (sampleTick) begin
      case (state)
        S_IDLE: begin
          tickCnt <= '0;
          if (!rxLine) state <= S_START;
        end
        S_START: begin
          if (midStart) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= rxLine ? S_IDLE : S_DATA;
          end else tickCnt <= tickCnt + 1'b1;
        end
        S_DATA: begin
          if (midBit) begin
            tickCnt <= '0;
            bitCnt  <= bitCnt + 1'b1;
            if (bitCnt == BW'(DBITS - 1)) state <= parityOn ? S_PAR : S_STOP;
          end else tickCnt <= tickCnt + 1'b1;
        end
        S_PAR: begin
          if (midBit) begin
            tickCnt <= '0;
            state   <= S_STOP;
          end else tickCnt <= tickCnt + 1'b1;
        end
        S_STOP: begin
          if (midBit) begin
            tickCnt <= '0;
            state   <= twoStop ? S_STOP2 : S_IDLE;
          end else tickCnt <= tickCnt + 1'b1;
        end
        default: begin  // S_STOP2: second stop bit is timed, never checked
          if (midBit) begin
            tickCnt <= '0;
            state   <= S_IDLE;
          end else tickCnt <= tickCnt + 1'b1;
        end
      endcase
    end
  end

  // R8: a disabled receiver produces no sample strobe on the next cycle
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (strobe == '0));

  // R5: with two stop bits, the checked stop sample is followed by a silent bit period
  assert_second_stop_unchecked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopBit && twoStop && rxEnable) |=> (state == S_STOP2));
endmodule

// File: rtl/rxline_dp.sv
module rxline_dp
  import rxline_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        strobe,
  input  logic             rxLine,
  input  logic             parityOn,
  input  logic             parityOdd,
  input  logic             standby,
  input  logic             regRead,
  input  logic             regWrite,
  input  logic             regWdata,
  input  logic             qPop,
  output logic             errFlag,
  output logic [DBITS-1:0] qData,
  output logic             qFrameErr,
  output logic             qParityErr,
  output logic             qEmpty,
  output logic             qFull,
  output logic             overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DBITS + 2;

  logic [DBITS-1:0] shiftReg;
  logic             parReg;
  logic [EW-1:0]    mem [DEPTH];
  logic [AW:0]      wrPtr, rdPtr, used;
  logic [EW-1:0]    head;
  logic             armed;
  logic             charFe, charPe, push, errSet, clearReq;

  assign charFe   = !rxLine;
  assign charPe   = parityOn && ((^shiftReg ^ parReg) != parityOdd);
  assign push     = strobe.stopBit;
  assign errSet   = push && (charFe || charPe);
  assign clearReq = regWrite && !regWdata && armed;

  assign used   = wrPtr - rdPtr;
  assign qEmpty = (used == '0);
  assign qFull  = (used == (AW + 1)'(DEPTH));
  assign head   = mem[rdPtr[AW-1:0]];
  assign qData      = head[DBITS-1:0];
  assign qFrameErr  = head[DBITS];
  assign qParityErr = head[DBITS+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parReg   <= 1'b0;
    end else begin
      if (strobe.dataBit) shiftReg <= {rxLine, shiftReg[DBITS-1:1]};
      if (strobe.parBit)  parReg   <= rxLine;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !qFull) mem[wrPtr[AW-1:0]] <= {charPe, charFe, shiftReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push && !qFull) wrPtr <= wrPtr + 1'b1;
      if (qPop && !qEmpty) rdPtr <= rdPtr + 1'b1;
      if (standby) overrun <= 1'b0;
      else if (push && qFull) overrun <= 1'b1;
    end
  end

  // sticky error with read-then-write-0 clearing; hardware set has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      armed   <= 1'b0;
    end else if (standby) begin
      errFlag <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (errSet) errFlag <= 1'b1;
      else if (clearReq) errFlag <= 1'b0;
      if (regWrite) armed <= 1'b0;
      else if (regRead && errFlag) armed <= 1'b1;
    end
  end

  assert_stop_low_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopBit && !rxLine && !standby) |=> errFlag);

  assert_write_without_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && regWrite && !armed && !standby) |=> errFlag);

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errSet && regWrite && !regWdata && !standby) |=> errFlag);

  assert_standby_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (!errFlag && !overrun));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (push && qFull && !standby) |=> (overrun && $stable(wrPtr)));

  always_comb begin
    if (rstN) assert_count_bound_R10: assert (used <= (AW + 1)'(DEPTH));
  end
endmodule

// File: rtl/rxline_capture.sv
module rxline_capture
  import rxline_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DBITS = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxLine,
  input  logic             rxEnable,
  input  logic             parityOn,
  input  logic             parityOdd,
  input  logic             twoStop,
  input  logic             standby,
  input  logic             regRead,
  input  logic             regWrite,
  input  logic             regWdata,
  input  logic             qPop,
  output logic             errFlag,
  output logic [DBITS-1:0] qData,
  output logic             qFrameErr,
  output logic             qParityErr,
  output logic             qEmpty,
  output logic             qFull,
  output logic             overrun
);
  rxStrobe_t strobe;

  rxline_ctrl #(.OSR(OSR), .DBITS(DBITS)) ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .parityOn(parityOn), .twoStop(twoStop), .strobe(strobe)
  );

  rxline_dp #(.DEPTH(DEPTH), .DBITS(DBITS)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxLine(rxLine),
    .parityOn(parityOn), .parityOdd(parityOdd), .standby(standby),
    .regRead(regRead), .regWrite(regWrite), .regWdata(regWdata), .qPop(qPop),
    .errFlag(errFlag), .qData(qData), .qFrameErr(qFrameErr), .qParityErr(qParityErr),
    .qEmpty(qEmpty), .qFull(qFull), .overrun(overrun)
  );
endmodule

// File: tb/rxline_capture_test.sv
`timescale 1ns/1ps
module rxline_capture_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b1;
  logic rxLine = 1'b1, rxEnable = 1'b1, parityOn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic standby = 1'b0, regRead = 1'b0, regWrite = 1'b0, regWdata = 1'b0, qPop = 1'b0;
  logic errFlag, qFrameErr, qParityErr, qEmpty, qFull, overrun;
  logic [7:0] qData;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  rxline_capture #(.DEPTH(4)) uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine), .rxEnable(rxEnable),
    .parityOn(parityOn), .parityOdd(parityOdd), .twoStop(twoStop), .standby(standby),
    .regRead(regRead), .regWrite(regWrite), .regWdata(regWdata), .qPop(qPop),
    .errFlag(errFlag), .qData(qData), .qFrameErr(qFrameErr), .qParityErr(qParityErr),
    .qEmpty(qEmpty), .qFull(qFull), .overrun(overrun)
  );

  typedef struct packed {
    logic [7:0] d;
    logic par, odd, two, brk, flip, bad2, expFe, expPe;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R1 plain
    '{8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 even ok
    '{8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 odd bad
    '{8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 framing
    '{8'h5E, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 bad 2nd stop
    '{8'h07, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}   // R3/R4 both
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bitOut(input logic v);
    @(negedge clk) rxLine = v;
    repeat (15) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic par, input logic odd,
                           input logic two, input logic brk, input logic flip, input logic bad2);
    logic pb;
    parityOn = par; parityOdd = odd; twoStop = two;
    pb = (^d) ^ odd ^ flip;
    bitOut(1'b0);
    for (int i = 0; i < 8; i++) bitOut(d[i]);
    if (par) bitOut(pb);
    bitOut(!brk);
    if (two) bitOut(!bad2);
    bitOut(1'b1);
    repeat (8) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk) qPop = 1'b1;
    @(negedge clk) qPop = 1'b0;
  endtask

  task automatic regRd();
    @(negedge clk) regRead = 1'b1;
    @(negedge clk) regRead = 1'b0;
  endtask

  task automatic regWr(input logic v);
    @(negedge clk) begin regWrite = 1'b1; regWdata = v; end
    @(negedge clk) regWrite = 1'b0;
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 reset qEmpty", qEmpty, 1);
    chk("R9 reset errFlag", errFlag, 0);
    chk("R9 reset overrun", overrun, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    foreach (VEC[k]) begin
      sendFrame(VEC[k].d, VEC[k].par, VEC[k].odd, VEC[k].two, VEC[k].brk, VEC[k].flip, VEC[k].bad2);
      chk("R1 entry present", qEmpty, 0);
      chk("R1 data", qData, VEC[k].d);
      chk("R3 frame tag", qFrameErr, VEC[k].expFe);
      chk("R4 parity tag", qParityErr, VEC[k].expPe);
      chk("R3/R4 errFlag", errFlag, VEC[k].expFe | VEC[k].expPe);
      pop();
      chk("R5/R11 single entry", qEmpty, 1);
      regRd(); regWr(1'b0);
      chk("R6 cleared by handshake", errFlag, 0);
    end

    // R2 start glitch
    @(negedge clk) rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 glitch ignored", qEmpty, 1);

    // R3 error then continuing reception, R11 ordering
    sendFrame(8'h4B, 0, 0, 0, 1, 0, 0);
    sendFrame(8'hC3, 0, 0, 0, 0, 0, 0);
    chk("R11 first data", qData, 8'h4B);
    chk("R3 first frame tag", qFrameErr, 1);
    pop();
    chk("R3 next frame data", qData, 8'hC3);
    chk("R11 second frame tag", qFrameErr, 0);
    pop();

    // R6 write without read, write of 1
    regWr(1'b0);
    chk("R6 write0 without read keeps", errFlag, 1);
    regRd(); regWr(1'b1);
    chk("R6 write1 keeps", errFlag, 1);
    regWr(1'b0);
    chk("R6 write1 consumed read", errFlag, 1);

    // R7 set and clear in the same cycle
    regRd();
    fork
      sendFrame(8'h99, 0, 0, 0, 1, 0, 0);
      begin
        repeat (153) @(negedge clk);
        regWrite = 1'b1; regWdata = 1'b0;
        @(negedge clk) regWrite = 1'b0;
      end
    join
    chk("R7 set wins over clear", errFlag, 1);
    chk("R7 entry stored", qFrameErr, 1);
    pop();

    // R8 disable keeps flag, no reception
    @(negedge clk) rxEnable = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 flag kept when disabled", errFlag, 1);
    sendFrame(8'h12, 0, 0, 0, 0, 0, 0);
    chk("R8 nothing received while disabled", qEmpty, 1);
    @(negedge clk) rxEnable = 1'b1;
    chk("R8 flag kept after re-enable", errFlag, 1);

    // R9 standby
    @(negedge clk) standby = 1'b1;
    @(negedge clk) standby = 1'b0;
    chk("R9 standby clears flag", errFlag, 0);

    // R10 overrun with depth 4
    for (int i = 1; i <= 5; i++) sendFrame(8'(i * 17), 0, 0, 0, 0, 0, 0);
    chk("R10 full", qFull, 1);
    chk("R10 overrun", overrun, 1);
    for (int i = 1; i <= 4; i++) begin
      chk("R10 kept entry", qData, 8'(i * 17));
      pop();
    end
    chk("R10 fifth dropped", qEmpty, 1);
    @(negedge clk) standby = 1'b1;
    @(negedge clk) standby = 1'b0;
    chk("R9 standby clears overrun", overrun, 0);

    finish();
  end
endmodule